// File: doc/BRIEF.md
# Dual-Plane Per-Pixel Colour Selector

This block sits in a display scanout path and builds one 24-bit RGB pixel at a time from three memory planes that share one raster. The first plane holds one 8-bit palette index per pixel. The second holds a 32-bit direct-colour word per pixel. The third holds a 32-bit control word per pixel, and that word decides which of the first two supplies the pixel. Every plane keeps a fixed line pitch of 1024 pixels, whatever the active width.

A frame begins with a one-cycle start pulse. The active width, height and a true-colour enable are captured at that pulse. The block then walks the raster in row order and issues one fetch at a time on a request/response memory port. An index is resolved through an external palette port that answers in the same cycle. Each finished pixel goes out on a valid/ready stream, marked with start-of-line and end-of-frame flags. When the true-colour enable is low, only the index plane is fetched.

Top module: `pixel_plane_selector`

## Requirements
- R1: After reset, `busy`, `mem_req_valid` and `pix_valid` are low.
- R2: A start pulse seen while idle, with non-zero width and height, captures width, height and mode, and `busy` is high from the next cycle. A start pulse during a frame, or with a zero width or height, has no effect. Input changes during a frame are not seen by that frame.
- R3: A frame emits exactly width×height pixels in row order, then `busy` falls. `pix_sol` marks column 0 and `pix_eof` marks the last pixel of the frame. No request or pixel appears while idle.
- R4: Plane codes are 0 for index, 1 for direct and 2 for control. The request address for pixel (x,y) is y*1024+x on the index plane and 4*(y*1024+x) on the other two planes. Columns at or beyond the active width are never requested.
- R5: A 32-bit response holds the byte at the lowest address in bits 7:0. The block byte-swaps each word, so the control code is `mem_rsp_data[7:0]`.
- R6: In true-colour mode each pixel first fetches its control word. If the code equals 0x03, the block next fetches the direct word and emits red, green, blue = `mem_rsp_data[15:8]`, `[23:16]`, `[31:24]`. The index plane is not fetched for that pixel.
- R7: For any other control code, the block fetches the index byte (`mem_rsp_data[7:0]`), presents it on `pal_index` and emits `pal_rgb`. The direct plane is not fetched for that pixel.
- R8: In 8-bit mode only the index plane is fetched, and every pixel takes the palette colour.
- R9: A request, once raised, holds its plane and address until it is accepted.
- R10: Under back-pressure the pixel and its flags stay stable. No pixel is dropped or repeated.
- R11: At most one memory request is outstanding. No new request is raised until the previous response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle request to scan a frame |
| cfg_width | input | 11 | Active pixels per line, 1..1024 |
| cfg_height | input | 11 | Active lines, 1..768 |
| cfg_truecolor | input | 1 | 1: control plane selects source; 0: palette only |
| mem_req_valid | output | 1 | Fetch request |
| mem_req_ready | input | 1 | Fetch request accepted |
| mem_req_plane | output | 2 | 0 index, 1 direct, 2 control |
| mem_req_addr | output | 22 | Byte address inside the plane |
| mem_rsp_valid | input | 1 | Fetch data returned |
| mem_rsp_data | input | 32 | Returned word, lowest-address byte in bits 7:0 |
| pal_index | output | 8 | Palette lookup index |
| pal_rgb | input | 24 | Palette colour for `pal_index`, same cycle |
| pix_valid | output | 1 | Output pixel valid |
| pix_ready | input | 1 | Sink accepts pixel |
| pix_rgb | output | 24 | Pixel colour, red 23:16, green 15:8, blue 7:0 |
| pix_sol | output | 1 | Pixel is column 0 of its line |
| pix_eof | output | 1 | Pixel is the last of the frame |
| busy | output | 1 | Frame scan in progress |

## Verification
The bench builds control words that hold 0x03 in their top byte but not in their first byte. A block that skipped the byte swap would take those pixels as true colour and emit the wrong colour. Wide frames (1024 columns) and a tall single-column frame check the line-pitch address of the last column and the last row. A design that packed lines by active width, or that wrapped at the wrong column, gives an address mismatch. A start pulse with altered width and mode arrives in the middle of each larger frame. A design that restarted, or that took the new values, would emit the wrong pixel count or sequence. Random ready and response delays check that a stalled pixel is neither lost nor repeated, and that requests never overlap.

// File: rtl/pxsel_pkg.sv
`timescale 1ns/1ps
package pxsel_pkg;

    typedef enum logic [1:0] {
        PLANE_IDX = 2'd0,
        PLANE_DIR = 2'd1,
        PLANE_CTL = 2'd2
    } plane_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_WAIT = 3'd2,
        ST_LOOK = 3'd3,
        ST_EMIT = 3'd4
    } state_e;

    // memory words arrive lowest-address byte first in bits 7:0
    function automatic logic [31:0] swap_bytes(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/pxsel_raster.sv
`timescale 1ns/1ps
module pxsel_raster #(
    parameter int X_W   = 10,
    parameter int Y_W   = 10,
    parameter int DIM_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [DIM_W-1:0] w_in,
    input  logic [DIM_W-1:0] h_in,
    output logic [X_W-1:0]   x,
    output logic [Y_W-1:0]   y,
    output logic             first_col,
    output logic             last_px
);
    typedef struct packed {
        logic [X_W-1:0]   x;
        logic [Y_W-1:0]   y;
        logic [DIM_W-1:0] w;
        logic [DIM_W-1:0] h;
    } pos_t;

    pos_t r_d, r_q;
    logic last_col, last_row;

    assign last_col  = (DIM_W'(r_q.x) == r_q.w - DIM_W'(1));
    assign last_row  = (DIM_W'(r_q.y) == r_q.h - DIM_W'(1));
    assign first_col = (r_q.x == '0);
    assign last_px   = last_col && last_row;
    assign x         = r_q.x;
    assign y         = r_q.y;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.x = '0;
            r_d.y = '0;
            r_d.w = w_in;
            r_d.h = h_in;
        end else if (step) begin
            if (last_col) begin
                r_d.x = '0;
                r_d.y = r_q.y + Y_W'(1);
            end else begin
                r_d.x = r_q.x + X_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/pxsel_addr.sv
`timescale 1ns/1ps
module pxsel_addr
    import pxsel_pkg::*;
#(
    parameter int X_W         = 10,
    parameter int Y_W         = 10,
    parameter int STRIDE_LOG2 = 10,
    localparam int OFF_W      = Y_W + STRIDE_LOG2,
    localparam int ADDR_W     = OFF_W + 2
) (
    input  plane_e            plane,
    input  logic [X_W-1:0]    x,
    input  logic [Y_W-1:0]    y,
    output logic [ADDR_W-1:0] addr
);
    logic [OFF_W-1:0] off;

    // line pitch is fixed; x never reaches the pitch
    assign off = {y, {STRIDE_LOG2{1'b0}}} + OFF_W'(x);

    always_comb begin
        if (plane == PLANE_IDX) addr = ADDR_W'(off);
        else                    addr = {off, 2'b00};
    end
endmodule

// File: rtl/pxsel_decode.sv
`timescale 1ns/1ps
module pxsel_decode
    import pxsel_pkg::*;
#(
    parameter logic [7:0] TC_CODE = 8'h03
) (
    input  logic [31:0] word,
    output logic        tc_hit,
    output logic [23:0] rgb
);
    logic [31:0] sw;

    assign sw     = swap_bytes(word);
    assign tc_hit = (sw[31:24] == TC_CODE);
    assign rgb    = sw[23:0];
endmodule

// File: rtl/pixel_plane_selector.sv
`timescale 1ns/1ps
module pixel_plane_selector
    import pxsel_pkg::*;
#(
    parameter int         MAX_W    = 1024,
    parameter int         MAX_H    = 768,
    parameter int         STRIDE   = 1024,
    parameter logic [7:0] TC_CODE  = 8'h03,
    localparam int X_W         = $clog2(MAX_W),
    localparam int Y_W         = $clog2(MAX_H),
    localparam int DIM_W       = $clog2(((MAX_W > MAX_H) ? MAX_W : MAX_H) + 1),
    localparam int STRIDE_LOG2 = $clog2(STRIDE),
    localparam int ADDR_W      = Y_W + STRIDE_LOG2 + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [DIM_W-1:0]  cfg_width,
    input  logic [DIM_W-1:0]  cfg_height,
    input  logic              cfg_truecolor,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [1:0]        mem_req_plane,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic [7:0]        pal_index,
    input  logic [23:0]       pal_rgb,
    output logic              pix_valid,
    input  logic              pix_ready,
    output logic [23:0]       pix_rgb,
    output logic              pix_sol,
    output logic              pix_eof,
    output logic              busy
);
    typedef struct packed {
        state_e      state;
        plane_e      plane;
        logic        mode;
        logic [7:0]  idx;
        logic [23:0] rgb;
    } ctl_t;

    ctl_t s_d, s_q;

    logic             r_load, r_step;
    logic [X_W-1:0]   cur_x;
    logic [Y_W-1:0]   cur_y;
    logic             first_col, last_px;
    logic             tc_hit;
    logic [23:0]      direct_rgb;
    logic             mode_q;

    pxsel_raster #(.X_W(X_W), .Y_W(Y_W), .DIM_W(DIM_W)) u_raster (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (r_load),
        .step      (r_step),
        .w_in      (cfg_width),
        .h_in      (cfg_height),
        .x         (cur_x),
        .y         (cur_y),
        .first_col (first_col),
        .last_px   (last_px)
    );

    pxsel_addr #(.X_W(X_W), .Y_W(Y_W), .STRIDE_LOG2(STRIDE_LOG2)) u_addr (
        .plane (s_q.plane),
        .x     (cur_x),
        .y     (cur_y),
        .addr  (mem_req_addr)
    );

    pxsel_decode #(.TC_CODE(TC_CODE)) u_decode (
        .word   (mem_rsp_data),
        .tc_hit (tc_hit),
        .rgb    (direct_rgb)
    );

    always_comb begin
        s_d    = s_q;
        r_load = 1'b0;
        r_step = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (frame_start && cfg_width != '0 && cfg_height != '0) begin
                    r_load    = 1'b1;
                    s_d.mode  = cfg_truecolor;
                    s_d.plane = cfg_truecolor ? PLANE_CTL : PLANE_IDX;
                    s_d.state = ST_REQ;
                end
            end
            ST_REQ: begin
                if (mem_req_ready) s_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    unique case (s_q.plane)
                        PLANE_CTL: begin
                            s_d.plane = tc_hit ? PLANE_DIR : PLANE_IDX;
                            s_d.state = ST_REQ;
                        end
                        PLANE_DIR: begin
                            s_d.rgb   = direct_rgb;
                            s_d.state = ST_EMIT;
                        end
                        default: begin
                            s_d.idx   = mem_rsp_data[7:0];
                            s_d.state = ST_LOOK;
                        end
                    endcase
                end
            end
            ST_LOOK: begin
                s_d.rgb   = pal_rgb;
                s_d.state = ST_EMIT;
            end
            ST_EMIT: begin
                if (pix_ready) begin
                    r_step = 1'b1;
                    if (last_px) begin
                        s_d.state = ST_IDLE;
                    end else begin
                        s_d.plane = s_q.mode ? PLANE_CTL : PLANE_IDX;
                        s_d.state = ST_REQ;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state <= ST_IDLE;
            s_q.plane <= PLANE_IDX;
            s_q.mode  <= 1'b0;
            s_q.idx   <= '0;
            s_q.rgb   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_q        = s_q.mode;
    assign mem_req_valid = (s_q.state == ST_REQ);
    assign mem_req_plane = s_q.plane;
    assign pal_index     = s_q.idx;
    assign pix_valid     = (s_q.state == ST_EMIT);
    assign pix_rgb       = s_q.rgb;
    assign pix_sol       = pix_valid && first_col;
    assign pix_eof       = pix_valid && last_px;
    assign busy          = (s_q.state != ST_IDLE);
endmodule

// File: rtl/pxsel_checker.sv
`timescale 1ns/1ps
module pxsel_checker #(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [1:0]        mem_req_plane,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              pix_valid,
    input logic              pix_ready,
    input logic [23:0]       pix_rgb,
    input logic              pix_sol,
    input logic              pix_eof,
    input logic              busy,
    input logic              mode_q
);
    logic outstanding;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            outstanding <= 1'b0;
        else if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
        else if (mem_rsp_valid)                outstanding <= 1'b0;
    end

    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_plane));

    a_r10_pix_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !pix_ready |=>
            pix_valid && $stable(pix_rgb) && $stable(pix_sol) && $stable(pix_eof));

    a_r8_index_only: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mode_q |-> mem_req_plane == 2'd0);

    a_r4_word_align: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_plane != 2'd0 |-> mem_req_addr[1:0] == 2'b00);

    a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !outstanding);

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pix_valid && !mem_req_valid);

    a_r3_eof_ends: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && pix_ready && pix_eof |=> !busy);
endmodule

bind pixel_plane_selector pxsel_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_plane (mem_req_plane),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .pix_valid     (pix_valid),
    .pix_ready     (pix_ready),
    .pix_rgb       (pix_rgb),
    .pix_sol       (pix_sol),
    .pix_eof       (pix_eof),
    .busy          (busy),
    .mode_q        (mode_q)
);

// File: tb/pixel_plane_selector_test.sv
`timescale 1ns/1ps
module pixel_plane_selector_test;
    localparam int ADDR_W = 22;
    localparam int DIM_W  = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_start = 1'b0;
    logic [DIM_W-1:0]  cfg_width = '0;
    logic [DIM_W-1:0]  cfg_height = '0;
    logic              cfg_truecolor = 1'b0;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic [1:0]        mem_req_plane;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [31:0]       mem_rsp_data = '0;
    logic [7:0]        pal_index;
    logic [23:0]       pal_rgb;
    logic              pix_valid;
    logic              pix_ready = 1'b0;
    logic [23:0]       pix_rgb;
    logic              pix_sol;
    logic              pix_eof;
    logic              busy;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    function automatic logic [31:0] mix(input int x, input int y, input logic [7:0] salt);
        logic [31:0] h;
        h = (32'(x) * 32'h9E3779B1) ^ (32'(y) * 32'h85EBCA77) ^ {4{salt}};
        h = h ^ (h >> 15);
        h = h * 32'h2C1B3C6D;
        h = h ^ (h >> 12);
        return h;
    endfunction

    function automatic logic [23:0] pal_fn(input logic [7:0] i);
        return {~i, i ^ 8'h5a, i + 8'd7};
    endfunction

    function automatic logic [31:0] idx_word(input int x, input int y);
        return mix(x, y, 8'h11);
    endfunction

    // first byte (bits 7:0) is the code; top byte is sometimes 0x03 as a decoy
    function automatic logic [31:0] ctl_word(input int x, input int y);
        logic [31:0] h;
        logic [7:0]  code, top;
        h = mix(x, y, 8'h22);
        if (h[1:0] == 2'b00) code = 8'h03;
        else begin
            code = h[15:8];
            if (code == 8'h03) code = 8'h04;
        end
        top = h[2] ? 8'h03 : h[31:24];
        return {top, h[23:16], h[11:4], code};
    endfunction

    function automatic logic [31:0] dir_word(input int x, input int y);
        return mix(x, y, 8'h33);
    endfunction

    function automatic bit is_tc(input int x, input int y);
        logic [31:0] c;
        c = ctl_word(x, y);
        return c[7:0] == 8'h03;
    endfunction

    function automatic logic [23:0] exp_pix(input int x, input int y, input bit mode);
        logic [31:0] d, i;
        if (mode && is_tc(x, y)) begin
            d = dir_word(x, y);
            return {d[15:8], d[23:16], d[31:24]};
        end
        i = idx_word(x, y);
        return pal_fn(i[7:0]);
    endfunction

    assign pal_rgb = pal_fn(pal_index);

    pixel_plane_selector uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start   (frame_start),
        .cfg_width     (cfg_width),
        .cfg_height    (cfg_height),
        .cfg_truecolor (cfg_truecolor),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_plane (mem_req_plane),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .pal_index     (pal_index),
        .pal_rgb       (pal_rgb),
        .pix_valid     (pix_valid),
        .pix_ready     (pix_ready),
        .pix_rgb       (pix_rgb),
        .pix_sol       (pix_sol),
        .pix_eof       (pix_eof),
        .busy          (busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic run_frame(input int w, input int h, input bit mode, input bit disturb);
        int consumed = 0;
        int fetch_no = 0;
        int total = w * h;
        int cyc = 0;
        int delay = 0;
        bit pend = 0;
        bit prev_stall = 0;
        bit done = 0;
        logic [23:0] prev_rgb = '0;
        logic [31:0] pend_data = '0;
        cfg_width     = DIM_W'(w);
        cfg_height    = DIM_W'(h);
        cfg_truecolor = mode;
        frame_start   = 1'b1;
        tick();
        frame_start = 1'b0;
        check(busy === 1'b1, "R2", "busy after start", 32'(busy), 32'd1);
        while (!done) begin
            cyc++;
            if (disturb && cyc == 7) begin
                frame_start   = 1'b1;
                cfg_width     = DIM_W'(w + 3);
                cfg_truecolor = !mode;
            end else begin
                frame_start = 1'b0;
            end
            // response channel
            mem_rsp_valid = 1'b0;
            if (mem_req_valid && pend)
                check(1'b0, "R11", "request while response pending", 32'd1, 32'd0);
            if (pend) begin
                if (delay == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pend_data;
                    pend = 0;
                end else begin
                    delay--;
                end
            end
            // request channel
            if (mem_req_valid && !pend && !mem_rsp_valid) begin
                mem_req_ready = ($urandom % 4) != 0;
                if (mem_req_ready) begin
                    int px, py, off;
                    logic [1:0] exp_plane;
                    px  = consumed % w;
                    py  = consumed / w;
                    off = py * 1024 + px;
                    if (!mode)              exp_plane = 2'd0;
                    else if (fetch_no == 0) exp_plane = 2'd2;
                    else                    exp_plane = is_tc(px, py) ? 2'd1 : 2'd0;
                    if (!mode)
                        check(mem_req_plane == exp_plane, "R8", "plane", 32'(mem_req_plane), 32'(exp_plane));
                    else if (exp_plane == 2'd1)
                        check(mem_req_plane == exp_plane, "R6", "plane", 32'(mem_req_plane), 32'(exp_plane));
                    else
                        check(mem_req_plane == exp_plane, "R7", "plane", 32'(mem_req_plane), 32'(exp_plane));
                    check(32'(mem_req_addr) == ((mem_req_plane == 2'd0) ? 32'(off) : 32'(off * 4)),
                          "R4", "address", 32'(mem_req_addr), 32'(off));
                    check(consumed < total, "R4", "fetch beyond frame", 32'(consumed), 32'(total));
                    case (mem_req_plane)
                        2'd0:    pend_data = idx_word(px, py);
                        2'd1:    pend_data = dir_word(px, py);
                        default: pend_data = ctl_word(px, py);
                    endcase
                    pend  = 1;
                    delay = $urandom % 3;
                    fetch_no++;
                    check(fetch_no <= (mode ? 2 : 1), "R5", "fetches per pixel", 32'(fetch_no), 32'd2);
                end
            end else begin
                mem_req_ready = 1'b0;
            end
            // pixel channel
            if (prev_stall)
                check(pix_valid && pix_rgb == prev_rgb, "R10", "stalled pixel changed",
                      {7'd0, pix_valid, pix_rgb}, {8'd1, prev_rgb});
            if (pix_valid) begin
                check(consumed < total, "R3", "extra pixel", 32'(consumed), 32'(total));
                pix_ready = ($urandom % 3) != 0;
                if (pix_ready && consumed < total) begin
                    int px, py;
                    logic [23:0] e;
                    px = consumed % w;
                    py = consumed / w;
                    e  = exp_pix(px, py, mode);
                    if (mode && is_tc(px, py))
                        check(pix_rgb == e, "R6", "direct colour", 32'(pix_rgb), 32'(e));
                    else
                        check(pix_rgb == e, "R7", "palette colour", 32'(pix_rgb), 32'(e));
                    check(pix_sol == (px == 0), "R3", "start of line", 32'(pix_sol), 32'(px == 0));
                    check(pix_eof == (consumed == total - 1), "R3", "end of frame",
                          32'(pix_eof), 32'(consumed == total - 1));
                    consumed++;
                    fetch_no = 0;
                end
                prev_stall = !pix_ready;
                prev_rgb   = pix_rgb;
            end else begin
                pix_ready  = ($urandom % 2) != 0;
                prev_stall = 0;
            end
            if (consumed == total && !busy) done = 1;
            if (cyc > 40 * total + 200) begin
                check(1'b0, "R3", "frame watchdog", 32'(consumed), 32'(total));
                done = 1;
            end
            if (!done) tick();
        end
        frame_start   = 1'b0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        pix_ready     = 1'b1;
        for (int k = 0; k < 4; k++) begin
            tick();
            check(!pix_valid && !mem_req_valid && !busy, "R3", "idle after frame",
                  {30'd0, pix_valid, mem_req_valid}, 32'd0);
        end
        cfg_truecolor = mode;
    endtask

    task automatic zero_start(input int w, input int h);
        cfg_width   = DIM_W'(w);
        cfg_height  = DIM_W'(h);
        frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
        for (int k = 0; k < 5; k++) begin
            check(!busy && !mem_req_valid && !pix_valid, "R2", "zero-size start ignored",
                  {29'd0, busy, mem_req_valid, pix_valid}, 32'd0);
            tick();
        end
    endtask

    initial begin
        #2000000;
        n_fails++;
        $display("FAIL R3 global watchdog expired: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        int seed_val;
        seed_val = $urandom(32'd20240611);
        rst_n = 1'b0;
        repeat (5) tick();
        check(!busy && !mem_req_valid && !pix_valid, "R1", "reset state",
              {29'd0, busy, mem_req_valid, pix_valid}, 32'd0);
        rst_n = 1'b1;
        tick();
        check(!busy && !mem_req_valid && !pix_valid, "R1", "after reset release",
              {29'd0, busy, mem_req_valid, pix_valid}, 32'd0);

        zero_start(0, 4);
        zero_start(5, 0);

        run_frame(1, 1, 1'b1, 1'b0);
        run_frame(1, 1, 1'b0, 1'b0);
        run_frame(4, 3, 1'b0, 1'b1);
        run_frame(6, 5, 1'b1, 1'b1);
        run_frame(1024, 1, 1'b1, 1'b0);
        run_frame(1024, 2, 1'b0, 1'b0);
        run_frame(1, 768, 1'b1, 1'b1);
        for (int t = 0; t < 10; t++) begin
            int w, h;
            w = 1 + ($urandom % 16);
            h = 1 + ($urandom % 8);
            run_frame(w, h, 1'($urandom % 2), (w * h) >= 4);
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule